// File: doc/BRIEF.md
# Partition Entry Cache for Process-Table Base Lookup

This block gives an address-translation unit the base address of the process table. The base does not come from a dedicated register. The block reads it from memory, from the doubleword that sits 8 bytes past an 8-byte-aligned pointer held in a partition-control register. Only one partition entry exists. The block fetches it once and keeps it, so later lookups return the base without touching memory.

The translation unit raises a level request and holds it. If the cached entry is valid, the base is returned in the same cycle. If the entry is invalid, the block starts one memory read and keeps the request pending until the memory acknowledge arrives. It then stores the returned doubleword and marks the entry valid.

Any write to the control register invalidates the entry. A read that is in flight when such a write lands, or whose acknowledge coincides with it, is completed on the memory side but its data is dropped. The next lookup then fetches from the new pointer.

Top module: `ptab_base_cache`

## Requirements
- R1: After reset the entry is invalid, no memory read is pending, and the control register is zero, so the first fetch reads address 0x8.
- R2: A request that misses issues a memory read at address ({ctl[63:3],3'b000} + 8); control bits [2:0] have no effect on the address.
- R3: Once raised, the memory read request stays high with an unchanged address until the cycle in which the acknowledge is sampled, and drops in the following cycle.
- R4: The cycle after an accepted acknowledge, the entry is valid; with the request held, base-valid is high and the base equals the acknowledged data.
- R5: While the entry is valid, a request is answered combinationally in its own cycle, and no memory read is issued however long requests continue.
- R6: A write to the control register makes the entry invalid from the next cycle; the next request reads memory at the address derived from the new value.
- R7: If the control register is written while a read is outstanding, the data returned by that read is discarded and the entry stays invalid; a held request then starts a new read from the new address.
- R8: If a control write and the read acknowledge fall in the same cycle, the write wins: the data is discarded and the entry stays invalid.
- R9: With no request from the translation unit, no memory read is issued, even while the entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Write strobe for the partition-control register |
| ctl_wr_data | input | 64 | New partition-control value |
| xl_req | input | 1 | Level request for the process-table base |
| xl_base_vld | output | 1 | Base is valid for the held request |
| xl_base | output | 64 | Process-table base from the cached entry |
| mem_rd_req | output | 1 | Memory read request, held until acknowledge |
| mem_rd_addr | output | 64 | Doubleword-aligned read address |
| mem_rd_ack | input | 1 | Memory read acknowledge, one-cycle pulse |
| mem_rd_data | input | 64 | Read data, valid with the acknowledge |

## Verification
The assertions assume three things about the inputs. The memory acknowledges only while a read request is high. The acknowledge lasts exactly one cycle per read. The translation unit holds its request level until base-valid is returned. The bench drives the memory model from the request it sees at the port, so an acknowledge only answers an open read and always drops after a single cycle. The two directed races, a control write during a pending read and a control write aligned with the acknowledge, are driven by hand on the falling edge, so their cycle relation is fixed.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    typedef enum logic {
        FILL_IDLE = 1'b0,
        FILL_WAIT = 1'b1
    } fill_st_e;

    localparam int unsigned DWORD_ALIGN_BITS = 3;
endpackage

// File: rtl/ptw_ctl_reg.sv
module ptw_ctl_reg
    import ptw_pkg::*;
#(
    parameter int unsigned AW        = 64,
    parameter int unsigned ENTRY_OFS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_data,
    output logic [AW-1:0] fetch_addr
);
    localparam int unsigned LB = DWORD_ALIGN_BITS;

    typedef struct packed {
        logic [AW-1:0] ctl;
    } ctl_st_t;

    ctl_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) s_d.ctl = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // pointer bits below the doubleword boundary are dropped
    assign fetch_addr = {s_q.ctl[AW-1:LB], {LB{1'b0}}} + AW'(ENTRY_OFS);

    // R2
    addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_addr[LB-1:0] == '0);
endmodule

// File: rtl/ptw_fill_fsm.sv
module ptw_fill_fsm
    import ptw_pkg::*;
#(
    parameter int unsigned AW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          need_fill,
    input  logic          ctl_wr,
    input  logic [AW-1:0] fetch_addr,
    input  logic          mem_ack,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          commit
);
    typedef struct packed {
        fill_st_e      st;
        logic          stale;
        logic [AW-1:0] addr;
    } fsm_st_t;

    fsm_st_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        commit = 1'b0;
        unique case (s_q.st)
            FILL_IDLE: begin
                // hold off for one cycle when the pointer changes this cycle
                if (need_fill && !ctl_wr) begin
                    s_d.st    = FILL_WAIT;
                    s_d.stale = 1'b0;
                    s_d.addr  = fetch_addr;
                end
            end
            FILL_WAIT: begin
                if (ctl_wr) s_d.stale = 1'b1;
                if (mem_ack) begin
                    commit    = !s_q.stale && !ctl_wr;
                    s_d.st    = FILL_IDLE;
                    s_d.stale = 1'b0;
                end
            end
            default: s_d.st = FILL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: FILL_IDLE, stale: 1'b0, addr: '0};
        else        s_q <= s_d;
    end

    assign mem_req  = (s_q.st == FILL_WAIT);
    assign mem_addr = s_q.addr;

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R3
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> !mem_req);

    // R7
    stale_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && ctl_wr && !mem_ack) |=> !commit);
endmodule

// File: rtl/ptw_entry_store.sv
module ptw_entry_store #(
    parameter int unsigned DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inval,
    input  logic          commit,
    input  logic [DW-1:0] fill_data,
    output logic          valid,
    output logic [DW-1:0] base
);
    typedef struct packed {
        logic          vld;
        logic [DW-1:0] entry;
    } ent_st_t;

    ent_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (inval) begin
            s_d.vld = 1'b0;
        end else if (commit) begin
            s_d.vld   = 1'b1;
            s_d.entry = fill_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign valid = s_q.vld;
    assign base  = s_q.entry;

    // R6
    inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inval |=> !valid);

    // R4
    fill_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !inval) |=> (valid && base == $past(fill_data)));
endmodule

// File: rtl/ptab_base_cache.sv
module ptab_base_cache #(
    parameter int unsigned AW        = 64,
    parameter int unsigned DW        = 64,
    parameter int unsigned ENTRY_OFS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr_en,
    input  logic [AW-1:0] ctl_wr_data,
    input  logic          xl_req,
    output logic          xl_base_vld,
    output logic [DW-1:0] xl_base,
    output logic          mem_rd_req,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rd_ack,
    input  logic [DW-1:0] mem_rd_data
);
    logic [AW-1:0] fetch_addr;
    logic          ent_valid;
    logic [DW-1:0] ent_base;
    logic          fill_commit;
    logic          need_fill;

    ptw_ctl_reg #(.AW(AW), .ENTRY_OFS(ENTRY_OFS)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (ctl_wr_en),
        .wr_data    (ctl_wr_data),
        .fetch_addr (fetch_addr)
    );

    assign need_fill = xl_req && !ent_valid;

    ptw_fill_fsm #(.AW(AW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .need_fill  (need_fill),
        .ctl_wr     (ctl_wr_en),
        .fetch_addr (fetch_addr),
        .mem_ack    (mem_rd_ack),
        .mem_req    (mem_rd_req),
        .mem_addr   (mem_rd_addr),
        .commit     (fill_commit)
    );

    ptw_entry_store #(.DW(DW)) u_ent (
        .clk       (clk),
        .rst_n     (rst_n),
        .inval     (ctl_wr_en),
        .commit    (fill_commit),
        .fill_data (mem_rd_data),
        .valid     (ent_valid),
        .base      (ent_base)
    );

    assign xl_base_vld = xl_req && ent_valid;
    assign xl_base     = ent_base;

    // R5
    hit_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xl_base_vld |=> !mem_rd_req);

    // R9
    idle_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!xl_req && !mem_rd_req) |=> !mem_rd_req);
endmodule

// File: tb/ptab_base_cache_test.sv
module ptab_base_cache_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr_en = 1'b0;
    logic [63:0] ctl_wr_data = '0;
    logic        xl_req = 1'b0;
    logic        xl_base_vld;
    logic [63:0] xl_base;
    logic        mem_rd_req;
    logic [63:0] mem_rd_addr;
    logic        mem_rd_ack;
    logic [63:0] mem_rd_data;

    logic        auto_mem = 1'b1;
    int          lat = 1;
    int          wcnt = 0;
    logic        a_ack = 1'b0;
    logic [63:0] a_data = '0;
    logic        m_ack = 1'b0;
    logic [63:0] m_data = '0;

    int          n_chk = 0;
    int          n_fail = 0;
    int          n_reads = 0;
    logic [63:0] last_addr = '0;
    int          cyc = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    assign mem_rd_ack  = auto_mem ? a_ack  : m_ack;
    assign mem_rd_data = auto_mem ? a_data : m_data;

    ptab_base_cache uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_wr_en   (ctl_wr_en),
        .ctl_wr_data (ctl_wr_data),
        .xl_req      (xl_req),
        .xl_base_vld (xl_base_vld),
        .xl_base     (xl_base),
        .mem_rd_req  (mem_rd_req),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_ack  (mem_rd_ack),
        .mem_rd_data (mem_rd_data)
    );

    function automatic logic [63:0] memval(input logic [63:0] a);
        return {a[31:0] ^ 32'hC0DE_0000, ~a[31:0]};
    endfunction

    // memory model: answers only an open read, one-cycle acknowledge
    always @(negedge clk) begin
        if (!auto_mem) begin
            a_ack <= 1'b0;
            wcnt  <= 0;
        end else if (mem_rd_req && !a_ack) begin
            if (wcnt >= lat) begin
                a_ack  <= 1'b1;
                a_data <= memval(mem_rd_addr);
                wcnt   <= 0;
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            a_ack <= 1'b0;
        end
    end

    always @(posedge clk) begin
        if (rst_n && mem_rd_req && mem_rd_ack) begin
            n_reads   <= n_reads + 1;
            last_addr <= mem_rd_addr;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ctl_write(input logic [63:0] v);
        @(negedge clk);
        ctl_wr_en = 1'b1;
        ctl_wr_data = v;
        @(negedge clk);
        ctl_wr_en = 1'b0;
    endtask

    task automatic wait_req();
        for (int i = 0; i < 50 && !mem_rd_req; i++) @(negedge clk);
    endtask

    task automatic wait_ack();
        for (int i = 0; i < 50 && !mem_rd_ack; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        check(!xl_base_vld, "R1 base_vld after reset", 64'(xl_base_vld), 0);
        check(!mem_rd_req, "R1 no read after reset", 64'(mem_rd_req), 0);
    endtask

    task automatic t_idle();
        int n0 = n_reads;
        repeat (6) begin
            @(negedge clk);
            if (mem_rd_req) check(0, "R9 read without request", 1, 0);
        end
        check(n_reads == n0, "R9 read count idle", 64'(n_reads), 64'(n0));
    endtask

    task automatic t_first_fetch();
        lat = 1;
        @(negedge clk);
        xl_req = 1'b1;
        #1;
        check(!xl_base_vld, "R1 invalid on first request", 64'(xl_base_vld), 0);
        wait_req();
        check(mem_rd_addr == 64'h8, "R1 first fetch address", mem_rd_addr, 64'h8);
        wait_ack();
        @(negedge clk);
        check(xl_base_vld, "R4 valid after ack", 64'(xl_base_vld), 1);
        check(xl_base == memval(64'h8), "R4 base data", xl_base, memval(64'h8));
        check(!mem_rd_req, "R3 request dropped after ack", 64'(mem_rd_req), 0);
        xl_req = 1'b0;
    endtask

    task automatic t_hit();
        int n0 = n_reads;
        @(negedge clk);
        xl_req = 1'b1;
        #1;
        check(xl_base_vld, "R5 hit same cycle", 64'(xl_base_vld), 1);
        check(xl_base == memval(64'h8), "R5 hit base", xl_base, memval(64'h8));
        repeat (5) begin
            @(negedge clk);
            if (mem_rd_req) check(0, "R5 read on hit", 1, 0);
        end
        check(n_reads == n0, "R5 no memory read on hit", 64'(n_reads), 64'(n0));
        xl_req = 1'b0;
    endtask

    task automatic t_rewrite();
        logic [63:0] a;
        ctl_write(64'h1007);
        a = 64'h1008;
        xl_req = 1'b1;
        #1;
        check(!xl_base_vld, "R6 invalid after write", 64'(xl_base_vld), 0);
        lat = 3;
        wait_req();
        check(mem_rd_addr == a, "R2 low bits ignored", mem_rd_addr, a);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (!mem_rd_ack)
                check(mem_rd_req && mem_rd_addr == a, "R3 request held", mem_rd_addr, a);
        end
        wait_ack();
        @(negedge clk);
        check(xl_base_vld && xl_base == memval(a), "R6 refetched base", xl_base, memval(a));
        check(last_addr == a, "R6 refetch address", last_addr, a);
        xl_req = 1'b0;
    endtask

    task automatic t_write_midfetch();
        ctl_write(64'h2000);
        lat = 3;
        xl_req = 1'b1;
        wait_req();
        check(mem_rd_addr == 64'h2008, "R2 address", mem_rd_addr, 64'h2008);
        ctl_wr_en = 1'b1;
        ctl_wr_data = 64'h3000;
        @(negedge clk);
        ctl_wr_en = 1'b0;
        wait_ack();
        @(negedge clk);
        check(!xl_base_vld, "R7 stale data dropped", 64'(xl_base_vld), 0);
        wait_req();
        check(mem_rd_addr == 64'h3008, "R7 refetch address", mem_rd_addr, 64'h3008);
        wait_ack();
        @(negedge clk);
        check(xl_base_vld && xl_base == memval(64'h3008), "R7 new base", xl_base, memval(64'h3008));
        xl_req = 1'b0;
    endtask

    task automatic t_write_at_ack();
        ctl_write(64'h4000);
        auto_mem = 1'b0;
        xl_req = 1'b1;
        wait_req();
        m_ack = 1'b1;
        m_data = memval(mem_rd_addr);
        ctl_wr_en = 1'b1;
        ctl_wr_data = 64'h5003;
        @(negedge clk);
        m_ack = 1'b0;
        ctl_wr_en = 1'b0;
        check(!xl_base_vld, "R8 write wins over ack", 64'(xl_base_vld), 0);
        @(negedge clk);
        check(mem_rd_req && mem_rd_addr == 64'h5008, "R8 refetch address", mem_rd_addr, 64'h5008);
        auto_mem = 1'b1;
        lat = 1;
        wait_ack();
        @(negedge clk);
        check(xl_base_vld && xl_base == memval(64'h5008), "R8 new base", xl_base, memval(64'h5008));
        xl_req = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_first_fetch();
        t_hit();
        t_rewrite();
        t_write_midfetch();
        t_write_at_ack();
        t_idle();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule